// File: doc/BRIEF.md
# Word/Byte Parallel Control-Register Write Port

This block receives writes for a 12-bit control register. The writes come from a host parallel bus that runs without a clock and has an active-low select and an active-low write strobe. The block brings select, strobe and data into the system clock domain through two-flop synchronisers. It combines select and strobe into a single gated strobe. When that gated strobe ends, the block commits the data word it registered while the strobe was active.

A static width input chooses between two modes:

- **Wide mode:** one write loads all twelve register bits.
- **Narrow mode:** a full load takes two writes that use only data lines 0 to 7, and data line 8 acts as the half-select.
  - A low-half write places its eight bits in a staging register and changes nothing visible.
  - A high-half write supplies register bits 8 to 11 on data lines 0 to 3. It then commits those bits together with the staged byte.

Every commit raises a single-cycle update pulse. A high-half write that carries nonzero bits on data lines 4 to 7 is still applied. It also sets a sticky error flag, which stays set until a dedicated clear input is pulsed.

Top module: `pbus_cfg_write`

## Requirements
- R1: While the synchronous active-high reset is asserted, and after it is released, the register output, the staging byte, the update pulse and the error flag are all zero.
- R2: With `wide_i` high, one write transfers `bus_i[11:0]` to `cfg_o` and issues one update pulse.
- R3: With `wide_i` low and `bus_i[8]` low, a write stores `bus_i[7:0]` as the staged low byte. `cfg_o` is left unchanged and no update pulse is issued.
- R4: With `wide_i` low and `bus_i[8]` high, a write sets `cfg_o` to {`bus_i[3:0]`, staged byte} and issues one update pulse.
- R5: A high-half write with any of `bus_i[7:4]` nonzero still commits bits 8 to 11, and it sets `proto_err_o`. The flag then stays set through later writes.
- R6: A pulse on `err_clr_i` clears `proto_err_o`, unless a faulty high-half write commits in the same cycle. In that case the flag stays set.
- R7: Strobe activity while `cs_n_i` is high has no effect on `cfg_o`, on the staged byte or on the update pulse.
- R8: When `cs_n_i` and `wr_n_i` are driven as one tied signal, each write is captured exactly as if the two were driven separately.
- R9: Each completed wide write or high-half write raises `cfg_upd_o` for exactly one clock cycle.
- R10: The committed value is the data held while the strobe was active. Data that changes together with the strobe's release is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_i | input | 1 | Static width select: 1 = twelve bits per write, 0 = two-step narrow writes |
| cs_n_i | input | 1 | Host chip select, active low, asynchronous |
| wr_n_i | input | 1 | Host write strobe, active low, asynchronous |
| bus_i | input | 12 | Host data lines; in narrow mode bit 8 is the half-select |
| err_clr_i | input | 1 | Clears the sticky protocol error flag |
| cfg_o | output | 12 | Control register contents |
| cfg_upd_o | output | 1 | One-cycle pulse on every register commit |
| proto_err_o | output | 1 | Sticky flag: high-half write with nonzero upper nibble |

## Verification
The bench exercises the main function with distinct patterns, and each one separates a different fault:

- **Wide writes with alternating and sparse bit patterns** catch crossed or dropped bus bits.
- **Narrow low-then-high pairs with different halves** show whether the staged byte and the nibble land in the right places. They also show whether a low write leaks to the output.
- **A high-half write straight after reset** shows that the staging byte starts from zero.
- **Strobes with select held high** tell the gated capture apart from capture on the write strobe alone.
- **Tied select and strobe** confirm that a simultaneous release is still caught.
- **Data changed exactly as the strobe is released** shows whether the value committed is the one held during the strobe or a later one.

// File: rtl/pbus_cfg_write.sv
module pbus_cfg_write #(
  parameter int REG_W  = 12,
  parameter int BYTE_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wide_i,
  input  logic             cs_n_i,
  input  logic             wr_n_i,
  input  logic [REG_W-1:0] bus_i,
  input  logic             err_clr_i,
  output logic [REG_W-1:0] cfg_o,
  output logic             cfg_upd_o,
  output logic             proto_err_o
);
  localparam int HI_W = REG_W - BYTE_W;

  logic [SYNC_N-1:0]            cs_sync, wr_sync, wide_sync;
  logic [SYNC_N-1:0][REG_W-1:0] bus_pipe;
  logic [REG_W-1:0]             hold;
  logic [BYTE_W-1:0]            stage;
  logic                         act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sync   <= '1;
      wr_sync   <= '1;
      wide_sync <= '0;
      bus_pipe  <= '0;
    end else begin
      cs_sync   <= {cs_sync[SYNC_N-2:0], cs_n_i};
      wr_sync   <= {wr_sync[SYNC_N-2:0], wr_n_i};
      wide_sync <= {wide_sync[SYNC_N-2:0], wide_i};
      bus_pipe  <= {bus_pipe[SYNC_N-2:0], bus_i};
    end
  end

  wire act    = ~cs_sync[SYNC_N-1] & ~wr_sync[SYNC_N-1];
  wire wide   = wide_sync[SYNC_N-1];
  wire cap    = act_q & ~act;
  wire sel_hi = hold[BYTE_W];
  wire cap_wd = cap & wide;
  wire cap_lo = cap & ~wide & ~sel_hi;
  wire cap_hi = cap & ~wide & sel_hi;
  wire hi_bad = cap_hi & (|hold[BYTE_W-1:HI_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q       <= 1'b0;
      hold        <= '0;
      stage       <= '0;
      cfg_o       <= '0;
      cfg_upd_o   <= 1'b0;
      proto_err_o <= 1'b0;
    end else begin
      act_q     <= act;
      cfg_upd_o <= cap_wd | cap_hi;
      if (act)    hold  <= bus_pipe[SYNC_N-1];
      if (cap_lo) stage <= hold[BYTE_W-1:0];
      if (cap_wd) cfg_o <= hold;
      else if (cap_hi) cfg_o <= {hold[HI_W-1:0], stage};
      if (hi_bad) proto_err_o <= 1'b1;
      else if (err_clr_i) proto_err_o <= 1'b0;
    end
  end

  p_upd_single_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_upd_o |=> !cfg_upd_o);
  p_cfg_moves_with_upd_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_o != $past(cfg_o)) |-> cfg_upd_o);
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (proto_err_o && !err_clr_i) |=> proto_err_o);
  p_err_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (err_clr_i && !hi_bad) |=> !proto_err_o);
  p_err_source_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(proto_err_o) |-> $past(cap_hi));
  p_upd_needs_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_upd_o) |-> $past(act_q));
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (cfg_o == '0 && !cfg_upd_o && !proto_err_o));
endmodule

// File: tb/sim_pbus_cfg_write.sv
module sim_pbus_cfg_write;
  logic clk = 1'b0, rst = 1'b1;
  logic wide = 1'b1, cs_n = 1'b1, wr_n = 1'b1, clr = 1'b0;
  logic [11:0] bus = '0;
  logic [11:0] cfg;
  logic upd, err;
  int n_chk = 0, n_bad = 0, upd_cnt = 0, run = 0, max_run = 0;

  always #10 clk = ~clk;

  pbus_cfg_write u0 (.clk(clk), .rst(rst), .wide_i(wide), .cs_n_i(cs_n),
    .wr_n_i(wr_n), .bus_i(bus), .err_clr_i(clr), .cfg_o(cfg),
    .cfg_upd_o(upd), .proto_err_o(err));

  always @(negedge clk) begin
    if (upd) begin upd_cnt++; run++; if (run > max_run) max_run = run; end
    else run = 0;
  end

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic wr(logic [11:0] d, bit tied = 0, bit sel = 1, bit late = 0,
                    logic [11:0] d2 = '0);
    bus = d; tick(3);
    if (tied) begin cs_n = 1'b0; wr_n = 1'b0; end
    else begin cs_n = !sel; tick(2); wr_n = 1'b0; end
    tick(4);
    wr_n = 1'b1;
    if (tied) cs_n = 1'b1;
    if (late) bus = d2;
    tick(3);
    cs_n = 1'b1;
    tick(4);
  endtask

  task automatic t_reset();
    tick(3);
    chk("R1 cfg", cfg, 0); chk("R1 upd", upd, 0); chk("R1 err", err, 0);
    rst = 1'b0; tick(2);
    chk("R1 cfg after release", cfg, 0);
  endtask

  task automatic t_stage_zero();
    int c0;
    wide = 1'b0; tick(4);
    c0 = upd_cnt;
    wr(12'h105);
    chk("R1 staged byte zero", cfg, 12'h500);
    chk("R4 pulse count", upd_cnt - c0, 1);
  endtask

  task automatic t_word();
    int c0;
    wide = 1'b1; tick(4);
    c0 = upd_cnt;
    wr(12'hA5A); chk("R2 word A5A", cfg, 12'hA5A);
    wr(12'h801); chk("R2 word 801", cfg, 12'h801);
    wr(12'h5A5); chk("R2 word 5A5", cfg, 12'h5A5);
    chk("R2 pulse count", upd_cnt - c0, 3);
    chk("R2 no err", err, 0);
  endtask

  task automatic t_bytes();
    int c0;
    wide = 1'b0; tick(4);
    c0 = upd_cnt;
    wr(12'h0C3);
    chk("R3 cfg unchanged", cfg, 12'h5A5);
    chk("R3 no pulse", upd_cnt - c0, 0);
    wr(12'h109);
    chk("R4 commit", cfg, 12'h9C3);
    chk("R4 one pulse", upd_cnt - c0, 1);
    wr(12'h03C); wr(12'h106);
    chk("R4 second pair", cfg, 12'h63C);
    chk("R4 no err", err, 0);
  endtask

  task automatic t_err();
    wr(12'h011); wr(12'h1F2);
    chk("R5 accepted", cfg, 12'h211);
    chk("R5 err set", err, 1);
    wr(12'h022); wr(12'h103);
    chk("R5 err sticky", err, 1);
    chk("R5 later commit", cfg, 12'h322);
    clr = 1'b1; tick(1); clr = 1'b0; tick(1);
    chk("R6 cleared", err, 0);
  endtask

  task automatic t_no_cs();
    int c0 = upd_cnt;
    wide = 1'b1; tick(4);
    wr(12'hFFF, 0, 0);
    chk("R7 cfg unchanged", cfg, 12'h322);
    chk("R7 no pulse", upd_cnt - c0, 0);
    wide = 1'b0; tick(4);
    wr(12'h0EE, 0, 0); wr(12'h101);
    chk("R7 stage untouched", cfg, 12'h122);
  endtask

  task automatic t_tied();
    wide = 1'b1; tick(4);
    wr(12'h3C7, 1);
    chk("R8 tied word", cfg, 12'h3C7);
    wide = 1'b0; tick(4);
    wr(12'h044, 1); wr(12'h10B, 1);
    chk("R8 tied bytes", cfg, 12'hB44);
  endtask

  task automatic t_late();
    wide = 1'b1; tick(4);
    wr(12'h6D2, 0, 1, 1, 12'h999);
    chk("R10 held data", cfg, 12'h6D2);
    chk("R9 pulse width", max_run, 1);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_stage_zero(); t_word(); t_bytes(); t_err();
        t_no_cs(); t_tied(); t_late();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule